// File: doc/BRIEF.md
# Nested Interrupt Level Arbiter

This block sits beside a processor's sequencer and decides, at each instruction boundary, whether one of several hardware interrupt requests is taken. Every source carries a 3-bit level; a lower number means more urgent, and level 7 means the source is switched off. A request is eligible when the global interrupt enable is set and its level is numerically below the current level mask held in the block. The most urgent eligible request wins, with the lowest source index breaking ties.

On acceptance the block saves the current mask on an internal level stack and loads the accepted level as the new mask. A more urgent request can then preempt the running handler at a later boundary, while equal or less urgent ones wait. A return strobe pops the saved mask so the interrupted service resumes. Acceptance is withheld for one boundary after an instruction that touched the internal I/O area or that inhibits interrupts. It is withheld entirely while an extended I/O transfer service is active. An instruction may rewrite the mask directly, which can release requests that were waiting.

Top module: `irq_level_arb`

## Requirements
- R1: After reset the mask `ilm_o` is 7, `accept_o` is low, and the level stack is empty.
- R2: `accept_o` is high only in a cycle where `boundary_i` is high, and then `src_o` names an asserted request whose level is below `ilm_o`. A request does not need to be asserted between boundaries to be seen, because it is sampled at the boundary.
- R3: Among eligible requests the lowest level wins; among equal levels the lowest source index wins. `acc_lvl_o` gives the winner's level.
- R4: In the cycle after an acceptance, `ilm_o` equals the accepted level, and the previous mask has been pushed onto the stack.
- R5: While a handler runs at mask L, a request at level L or above stays pending, and a request below L is accepted at the next clean boundary.
- R6: A cycle with `ret_i` high pops the stack into `ilm_o`. On an empty stack, `ret_i` leaves `ilm_o` unchanged.
- R7: When `io_acc_i` or `inhibit_i` is high at a boundary, nothing is accepted at that boundary. An eligible request is accepted at the next boundary that has neither flag.
- R8: While `xio_busy_i` is high, no request is accepted.
- R9: With `iflag_i` low, no request is accepted. A cycle with `ilm_we_i` high loads `ilm_wdata_i` into the mask and accepts nothing in that cycle. Later boundaries judge eligibility against the written mask, so raising the mask releases a waiting equal-level request.
- R10: A cycle with `ret_i` high accepts nothing. When `ret_i` and `ilm_we_i` are both high and the stack is not empty, the pop wins.
- R11: With 8 levels saved on the stack, no request is accepted. After one pop, acceptance resumes.
- R12: A request that is still asserted when its handler returns is accepted again at the next eligible boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC | Per-source request lines, held until cleared by software |
| req_lvl_i | input | NSRC*LVL_W | Source levels; source k occupies bits [k*LVL_W +: LVL_W] |
| boundary_i | input | 1 | Instruction boundary strobe |
| io_acc_i | input | 1 | The instruction ending now touched the internal I/O area |
| inhibit_i | input | 1 | The instruction ending now is an interrupt-inhibit instruction |
| xio_busy_i | input | 1 | Extended I/O transfer service active |
| iflag_i | input | 1 | Global interrupt enable |
| ret_i | input | 1 | Interrupt return; pops the level stack |
| ilm_we_i | input | 1 | Instruction write of the level mask |
| ilm_wdata_i | input | LVL_W | Mask value written by the instruction |
| accept_o | output | 1 | One-cycle acceptance pulse, coincident with a boundary |
| src_o | output | SRC_W | Index of the accepted source |
| acc_lvl_o | output | LVL_W | Level of the accepted source, the next mask value |
| ilm_o | output | LVL_W | Current level mask |

## Verification
The bench targets four situations. The first is the same-level request that arrives during a handler: a design that compares with less-or-equal would nest it and re-enter its own level. The second is the boundary flagged by an I/O access or an inhibit instruction: a design that dropped the deferral would accept one instruction early, and one that latched the deferral would lose the following boundary. The third covers returns, including a return on an empty stack that must leave the mask at 7, a return that collides with a mask write, and a return while a boundary is active; a wrong priority here corrupts the mask or takes an interrupt against a stale level. The last fills the stack to its depth, where a missing full guard would overwrite saved levels.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    parameter int unsigned DEF_LVL_W = 3;

    // Where the next level mask comes from in a given cycle.
    typedef enum logic [1:0] {
        ILM_HOLD   = 2'd0,
        ILM_WRITE  = 2'd1,
        ILM_POP    = 2'd2,
        ILM_ACCEPT = 2'd3
    } ilm_sel_e;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int unsigned NSRC  = 8,
    parameter int unsigned LVL_W = 3,
    localparam int unsigned SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]       req_i,
    input  logic [NSRC*LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]      ilm_i,
    output logic                  valid_o,
    output logic [SRC_W-1:0]      idx_o,
    output logic [LVL_W-1:0]      lvl_o
);

    logic [NSRC-1:0] elig;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_elig
            assign elig[g] = req_i[g] && (lvl_i[g*LVL_W +: LVL_W] < ilm_i);
        end
    endgenerate

    // Strict less-than keeps the lowest index on equal levels.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!valid_o || (lvl_i[i*LVL_W +: LVL_W] < lvl_o))) begin
                valid_o = 1'b1;
                idx_o   = SRC_W'(i);
                lvl_o   = lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate (
    input  logic boundary_i,
    input  logic io_acc_i,
    input  logic inhibit_i,
    input  logic xio_busy_i,
    input  logic iflag_i,
    input  logic ret_i,
    input  logic ilm_we_i,
    input  logic stk_full_i,
    input  logic cand_i,
    output logic accept_o
);

    logic deferred;
    logic blocked;

    always_comb begin
        deferred = io_acc_i || inhibit_i;
        blocked  = xio_busy_i || !iflag_i || ret_i || ilm_we_i || stk_full_i;
        accept_o = boundary_i && cand_i && !deferred && !blocked;
    end

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
    parameter int unsigned LVL_W = 3,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_val_i,
    input  logic             pop_i,
    output logic [LVL_W-1:0] top_o,
    output logic             empty_o,
    output logic             full_o
);

    typedef struct packed {
        logic [DEPTH-1:0][LVL_W-1:0] mem;
        logic [CNT_W-1:0]            cnt;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [CNT_W-1:0] top_pos;

    always_comb begin
        stk_d   = stk_q;
        empty_o = (stk_q.cnt == '0);
        full_o  = (stk_q.cnt == CNT_W'(DEPTH));
        top_pos = stk_q.cnt - CNT_W'(1);
        top_o   = stk_q.mem[top_pos[IDX_W-1:0]];
        if (push_i && !full_o) begin
            stk_d.mem[stk_q.cnt[IDX_W-1:0]] = push_val_i;
            stk_d.cnt = stk_q.cnt + CNT_W'(1);
        end else if (pop_i && !empty_o) begin
            stk_d.cnt = top_pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
    import irq_arb_pkg::*;
#(
    parameter int unsigned NSRC      = 8,
    parameter int unsigned LVL_W     = DEF_LVL_W,
    parameter int unsigned STK_DEPTH = 8,
    localparam int unsigned SRC_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       req_i,
    input  logic [NSRC*LVL_W-1:0] req_lvl_i,
    input  logic                  boundary_i,
    input  logic                  io_acc_i,
    input  logic                  inhibit_i,
    input  logic                  xio_busy_i,
    input  logic                  iflag_i,
    input  logic                  ret_i,
    input  logic                  ilm_we_i,
    input  logic [LVL_W-1:0]      ilm_wdata_i,
    output logic                  accept_o,
    output logic [SRC_W-1:0]      src_o,
    output logic [LVL_W-1:0]      acc_lvl_o,
    output logic [LVL_W-1:0]      ilm_o
);

    typedef struct packed {
        logic [LVL_W-1:0] ilm;
    } arb_t;

    arb_t arb_d, arb_q;

    logic             cand;
    logic [SRC_W-1:0] cand_idx;
    logic [LVL_W-1:0] cand_lvl;
    logic             acc;
    logic             pop_ok;
    logic [LVL_W-1:0] stk_top;
    logic             stk_empty;
    logic             stk_full;
    ilm_sel_e         sel;

    irq_pick #(
        .NSRC  (NSRC),
        .LVL_W (LVL_W)
    ) u_pick (
        .req_i   (req_i),
        .lvl_i   (req_lvl_i),
        .ilm_i   (arb_q.ilm),
        .valid_o (cand),
        .idx_o   (cand_idx),
        .lvl_o   (cand_lvl)
    );

    irq_accept_gate u_gate (
        .boundary_i (boundary_i),
        .io_acc_i   (io_acc_i),
        .inhibit_i  (inhibit_i),
        .xio_busy_i (xio_busy_i),
        .iflag_i    (iflag_i),
        .ret_i      (ret_i),
        .ilm_we_i   (ilm_we_i),
        .stk_full_i (stk_full),
        .cand_i     (cand),
        .accept_o   (acc)
    );

    irq_lvl_stack #(
        .LVL_W (LVL_W),
        .DEPTH (STK_DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (acc),
        .push_val_i (arb_q.ilm),
        .pop_i      (ret_i),
        .top_o      (stk_top),
        .empty_o    (stk_empty),
        .full_o     (stk_full)
    );

    always_comb begin
        arb_d  = arb_q;
        pop_ok = ret_i && !stk_empty;
        if (pop_ok) begin
            sel = ILM_POP;
        end else if (ilm_we_i) begin
            sel = ILM_WRITE;
        end else if (acc) begin
            sel = ILM_ACCEPT;
        end else begin
            sel = ILM_HOLD;
        end
        case (sel)
            ILM_POP:    arb_d.ilm = stk_top;
            ILM_WRITE:  arb_d.ilm = ilm_wdata_i;
            ILM_ACCEPT: arb_d.ilm = cand_lvl;
            default:    arb_d.ilm = arb_q.ilm;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= '{ilm: '1};
        end else begin
            arb_q <= arb_d;
        end
    end

    assign accept_o  = acc;
    assign src_o     = cand_idx;
    assign acc_lvl_o = cand_lvl;
    assign ilm_o     = arb_q.ilm;

endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
    parameter int unsigned NSRC  = 8,
    parameter int unsigned LVL_W = 3,
    localparam int unsigned SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NSRC-1:0]       req_i,
    input logic                  boundary_i,
    input logic                  io_acc_i,
    input logic                  inhibit_i,
    input logic                  xio_busy_i,
    input logic                  iflag_i,
    input logic                  ret_i,
    input logic                  ilm_we_i,
    input logic                  accept_o,
    input logic [SRC_W-1:0]      src_o,
    input logic [LVL_W-1:0]      acc_lvl_o,
    input logic [LVL_W-1:0]      ilm_o
);

    // R2
    accept_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> boundary_i);

    // R2
    accept_has_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> req_i[src_o]);

    // R5
    accept_beats_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (acc_lvl_o < ilm_o));

    // R4
    mask_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (ilm_o == $past(acc_lvl_o)));

    // R7
    deferred_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_acc_i || inhibit_i) |-> !accept_o);

    // R8
    xio_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xio_busy_i |-> !accept_o);

    // R9
    iflag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iflag_i || ilm_we_i) |-> !accept_o);

    // R10
    return_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |-> !accept_o);

endmodule

bind irq_level_arb irq_level_arb_chk #(
    .NSRC  (NSRC),
    .LVL_W (LVL_W)
) u_chk (.*);

// File: tb/irq_level_arb_tb.sv
module irq_level_arb_tb;

    localparam int NSRC = 8;
    localparam int LW   = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] req;
    logic [NSRC*LW-1:0] lvl;
    logic            boundary, io_acc, inhib, xio, iflag, ret, we;
    logic [LW-1:0]   wdata;
    logic            accept;
    logic [2:0]      src;
    logic [LW-1:0]   acc_lvl, ilm;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_level_arb u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_lvl_i(lvl),
        .boundary_i(boundary), .io_acc_i(io_acc), .inhibit_i(inhib),
        .xio_busy_i(xio), .iflag_i(iflag), .ret_i(ret),
        .ilm_we_i(we), .ilm_wdata_i(wdata),
        .accept_o(accept), .src_o(src), .acc_lvl_o(acc_lvl), .ilm_o(ilm)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_src(input int s, input int l, input bit on);
        lvl[s*LW +: LW] = l[LW-1:0];
        req[s] = on;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; lvl = '1; boundary = 0; io_acc = 0; inhib = 0;
        xio = 0; iflag = 1; ret = 0; we = 0; wdata = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Boundary cycle: check the combinational decision, then clock it in.
    task automatic bnd(input string tag, input bit exp_acc, input int exp_src, input int exp_lvl);
        boundary = 1'b1;
        #1;
        check({tag, " accept"}, int'(accept), int'(exp_acc));
        if (exp_acc) begin
            check({tag, " src"}, int'(src), exp_src);
            check({tag, " lvl"}, int'(acc_lvl), exp_lvl);
        end
        tick();
        boundary = 0; io_acc = 0; inhib = 0;
    endtask

    task automatic ret_pulse();
        ret = 1'b1;
        tick();
        ret = 1'b0;
    endtask

    task automatic wr_ilm(input int v);
        we = 1'b1; wdata = v[LW-1:0];
        tick();
        we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset ilm", int'(ilm), 7);
        check("R1 reset accept", int'(accept), 0);
        ret_pulse();
        check("R1/R6 pop on empty stack", int'(ilm), 7);
    endtask

    task automatic t_basic();
        do_reset();
        set_src(3, 4, 1);
        #1;
        check("R2 no accept off boundary", int'(accept), 0);
        tick();
        bnd("R2 accept at boundary", 1, 3, 4);
        check("R4 mask loaded", int'(ilm), 4);
        check("R2 single pulse", int'(accept), 0);
    endtask

    task automatic t_priority();
        do_reset();
        set_src(1, 5, 1); set_src(2, 3, 1); set_src(5, 3, 1);
        bnd("R3 tie lowest index", 1, 2, 3);
        do_reset();
        set_src(0, 6, 1); set_src(6, 2, 1); set_src(4, 7, 1);
        bnd("R3 lowest level", 1, 6, 2);
    endtask

    task automatic t_nesting();
        do_reset();
        set_src(4, 5, 1);
        bnd("R5 first entry", 1, 4, 5);
        set_src(1, 5, 1); set_src(2, 6, 1);
        bnd("R5 same and lower level held", 0, 0, 0);
        set_src(7, 2, 1);
        bnd("R5 preempt", 1, 7, 2);
        check("R5 nested mask", int'(ilm), 2);
        ret_pulse();
        check("R6 resume mask", int'(ilm), 5);
        req[7] = 0; req[4] = 0;
        bnd("R5 still held after resume", 0, 0, 0);
        ret_pulse();
        check("R6 outer mask", int'(ilm), 7);
        bnd("R5 held request taken", 1, 1, 5);
    endtask

    task automatic t_reentry();
        do_reset();
        set_src(0, 3, 1);
        bnd("R12 first entry", 1, 0, 3);
        ret_pulse();
        bnd("R12 re-entry", 1, 0, 3);
    endtask

    task automatic t_defer();
        do_reset();
        set_src(2, 1, 1);
        io_acc = 1;
        bnd("R7 io access defers", 0, 0, 0);
        bnd("R7 next boundary", 1, 2, 1);
        do_reset();
        set_src(2, 1, 1);
        inhib = 1;
        bnd("R7 inhibit defers", 0, 0, 0);
        #1;
        check("R7 nothing between boundaries", int'(accept), 0);
        tick();
        bnd("R7 after inhibit", 1, 2, 1);
    endtask

    task automatic t_xio();
        do_reset();
        set_src(5, 0, 1);
        xio = 1;
        bnd("R8 busy blocks", 0, 0, 0);
        bnd("R8 busy blocks again", 0, 0, 0);
        check("R8 mask untouched", int'(ilm), 7);
        xio = 0;
        bnd("R8 after release", 1, 5, 0);
    endtask

    task automatic t_mask();
        do_reset();
        set_src(3, 4, 1);
        iflag = 0;
        bnd("R9 iflag clear blocks", 0, 0, 0);
        iflag = 1;
        we = 1; wdata = 3;
        bnd("R9 write cycle accepts nothing", 0, 0, 0);
        we = 0;
        check("R9 mask written", int'(ilm), 3);
        bnd("R9 level above mask held", 0, 0, 0);
        wr_ilm(6);
        bnd("R9 released by write", 1, 3, 4);
        do_reset();
        set_src(0, 5, 1);
        bnd("R9 entry", 1, 0, 5);
        set_src(1, 5, 1); req[0] = 0;
        bnd("R9 equal level held", 0, 0, 0);
        wr_ilm(7);
        bnd("R9 equal level released", 1, 1, 5);
    endtask

    task automatic t_ret_collide();
        do_reset();
        set_src(2, 4, 1);
        bnd("R10 entry", 1, 2, 4);
        set_src(6, 1, 1);
        ret = 1;
        bnd("R10 ret with boundary", 0, 0, 0);
        ret = 0;
        check("R10 popped", int'(ilm), 7);
        req = '0;
        set_src(2, 4, 1);
        bnd("R10 entry again", 1, 2, 4);
        ret = 1; we = 1; wdata = 1;
        tick();
        ret = 0; we = 0;
        check("R10 pop beats write", int'(ilm), 7);
    endtask

    task automatic t_full();
        do_reset();
        set_src(0, 6, 1);
        for (int k = 0; k < 8; k++) begin
            bnd("R11 fill", 1, 0, 6);
            wr_ilm(7);
        end
        bnd("R11 full stack blocks", 0, 0, 0);
        ret_pulse();
        check("R11 pop from full", int'(ilm), 7);
        bnd("R11 accept after pop", 1, 0, 6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_priority();
        t_nesting();
        t_reentry();
        t_defer();
        t_xio();
        t_mask();
        t_ret_collide();
        t_full();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule